// File: doc/BRIEF.md
# Clock Generator Configuration Serial Slave

This block is the configuration port of a clock generator. It listens to a two-wire serial bus (clock and data, open drain) as a slave only, loads a small bank of byte-wide configuration registers from the bus, and lets a bus master read them back. The register contents are presented in parallel so that the clock logic can use them to enable its outputs and to pick its operating mode.

A write starts with the device address and a write direction bit. The two bytes that follow carry a command code and a byte count. Both are acknowledged, but their values are thrown away. Every later byte goes into register 0, then register 1, and so on, until the master ends the transfer. A read starts with the device address and a read direction bit. The slave then returns register 0, register 1 and so on, most significant bit first, until the master stops acknowledging. There is no pointer and no count. SCL and SDA are sampled by a fast system clock. START and STOP are found from the sampled lines. A power-down input releases the bus pins and freezes the register bank.

The controller is a single state machine with these states: IDLE (waiting for START), ADDR (shifting in the address byte), ADDR_ACK (acknowledging a matching address), RX (shifting in a written byte), RX_ACK (acknowledging it), TX (shifting out a register byte) and TX_ACK (sampling the master's acknowledge). The transitions are:
- START from any state leads to ADDR.
- STOP or power-down from any state leads to IDLE.
- ADDR leads to ADDR_ACK when the address matches, and to IDLE when it does not.
- ADDR_ACK leads to RX for a write and to TX for a read.
- RX and RX_ACK alternate.
- TX leads to TX_ACK. TX_ACK goes back to TX when the master acknowledges, and to IDLE when it does not.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, register 0 holds 0x00 and registers 1 to 6 hold 0xFF. Register i appears on regs_out bits [8i+7:8i]. sda_drive_low is 0.
- R2: An address byte of 0xD2 (7-bit address 0x69 with the direction bit 0) is acknowledged. The next two bytes are also acknowledged, and their values change no register.
- R3: After the two ignored bytes, written bytes go to register 0, 1, 2 and so on in ascending order. A STOP after any complete byte ends the write. Registers that were not written keep their values.
- R4: Written bytes beyond register 6 are acknowledged and discarded.
- R5: An address byte of 0xD3 is acknowledged. The slave then sends register 0, 1, 2 and so on, most significant bit first, and sends 0xFF for positions past register 6. A master NACK ends the read.
- R6: An address byte that does not match is not acknowledged. No register changes. The slave ignores the bus until the next START.
- R7: A repeated START without a STOP restarts the sequence: a new address, two ignored bytes, then data from register 0.
- R8: While pwr_dn is 1, sda_drive_low stays 0, bus activity is ignored, and all registers keep their contents.
- R9: The slave changes sda_drive_low only after a falling edge of SCL, or after START, STOP or power-down. It never changes it during an SCL high phase of a data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset; loads register defaults |
| pwr_dn | input | 1 | Power-down: releases the bus and freezes the registers |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 releases it |
| regs_out | output | NUM_REGS*8 | Register bank, register i at bits [8i+7:8i] |

## Verification
The bench goes after the points in the byte sequence where a slip of one position goes unnoticed elsewhere:
- Zero data bytes and single data bytes. A design that counts the wrong number of dummy bytes would load the byte count into register 0.
- Writes of nine bytes. A design without a saturating pointer would wrap around and overwrite register 0 or 1.
- A repeated START right after a data byte. A design that does not restart the sequence would store the next command code as data.
- A foreign address, and an address sent during power-down. A design that acknowledges either would pull the line low, which a master sees as a phantom ACK.
- The level of SDA at the start and at the end of every SCL high phase during reads. A slave that changed SDA there would create a false START or STOP.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } phase_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now   = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_now && !scl_prev;
    assign scl_fall  = !scl_now && scl_prev;
    assign start_det = scl_now && scl_prev && sda_prev && !sda_s;
    assign stop_det  = scl_now && scl_prev && !sda_prev && sda_s;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int          NUM_REGS  = 7,
    parameter int          W         = 8,
    parameter logic [7:0]  DEF_FIRST = 8'h00,
    parameter logic [7:0]  DEF_REST  = 8'hFF,
    localparam int         PTR_W     = $clog2(NUM_REGS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_idx,
    input  logic [W-1:0]          wr_data,
    input  logic [PTR_W-1:0]      rd_idx,
    output logic [W-1:0]          rd_data,
    output logic [NUM_REGS*W-1:0] regs_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= (g == 0) ? W'(DEF_FIRST) : W'(DEF_REST);
            else if (wr_en && wr_idx == PTR_W'(g))
                q <= wr_data;
        end
        assign regs_flat[g*W +: W] = q;
    end

    always_comb begin
        rd_data = '1;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == PTR_W'(i))
                rd_data = regs_flat[i*W +: W];
        end
    end

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfg_pkg::*;
#(
    parameter int          NUM_REGS    = 7,
    parameter logic [6:0]  DEV_ADDR    = 7'h69,
    parameter int          DUMMY_BYTES = 2,
    parameter int          SYNC_STAGES = 2,
    localparam int         W           = BYTE_W,
    localparam int         PTR_W       = $clog2(NUM_REGS + 1),
    localparam int         SKIP_W      = $clog2(DUMMY_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_dn,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_drive_low,
    output logic [NUM_REGS*W-1:0] regs_out
);

    phase_e              state, state_d;
    logic                sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [W-1:0]        shreg;
    logic [3:0]          bit_cnt;
    logic [PTR_W-1:0]    ptr;
    logic [SKIP_W-1:0]   skip;
    logic                rd_flag;
    logic                m_nack;
    logic                byte_done;
    logic                wr_en;
    logic [W-1:0]        rd_data;
    logic                ptr_full;

    cfg_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_regfile #(.NUM_REGS(NUM_REGS), .W(W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (ptr),
        .wr_data   (shreg),
        .rd_idx    (ptr),
        .rd_data   (rd_data),
        .regs_flat (regs_out)
    );

    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign ptr_full  = (ptr == PTR_W'(NUM_REGS));
    assign wr_en     = (state == ST_RX) && byte_done && (skip == '0) && !ptr_full
                       && !pwr_dn && !start_det && !stop_det;

    // next state
    always_comb begin
        state_d = state;
        if (pwr_dn)
            state_d = ST_IDLE;
        else if (start_det)
            state_d = ST_ADDR;
        else if (stop_det)
            state_d = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done)
                                 state_d = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_d = rd_flag ? ST_TX : ST_RX;
                ST_RX:       if (byte_done) state_d = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) state_d = ST_RX;
                ST_TX:       if (scl_fall && bit_cnt == 4'd7) state_d = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_d = m_nack ? ST_IDLE : ST_TX;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            ptr     <= '0;
            skip    <= '0;
            rd_flag <= 1'b0;
            m_nack  <= 1'b0;
        end else begin
            state <= state_d;
            if (pwr_dn || stop_det) begin
                bit_cnt <= '0;
            end else if (start_det) begin
                bit_cnt <= '0;
                ptr     <= '0;
                skip    <= SKIP_W'(DUMMY_BYTES);
            end else begin
                unique case (state)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR)
                                rd_flag <= shreg[0];
                            else if (skip != '0)
                                skip <= skip - 1'b1;
                            else if (!ptr_full)
                                ptr <= ptr + 1'b1;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall && rd_flag) begin
                            shreg   <= rd_data;
                            bit_cnt <= '0;
                            if (!ptr_full) ptr <= ptr + 1'b1;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                bit_cnt <= '0;
                            end else begin
                                shreg   <= {shreg[W-2:0], 1'b1};
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise)
                            m_nack <= sda_s;
                        else if (scl_fall) begin
                            shreg   <= rd_data;
                            bit_cnt <= '0;
                            if (!ptr_full) ptr <= ptr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_drive_low = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_RX_ACK: sda_drive_low = 1'b1;
            ST_TX:                  sda_drive_low = !shreg[W-1];
            default:                sda_drive_low = 1'b0;
        endcase
        if (pwr_dn)
            sda_drive_low = 1'b0;
    end

endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
    parameter int NUM_REGS = 7,
    parameter int W        = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pwr_dn,
    input logic                  sda_drive_low,
    input logic [NUM_REGS*W-1:0] regs_out,
    input logic                  scl_fall,
    input logic                  start_det,
    input logic                  stop_det
);

    p_release_in_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |-> !sda_drive_low);

    p_hold_in_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> $stable(regs_out));

    p_write_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_out) |-> $past(scl_fall));

    p_sda_change_point_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |->
            ($past(scl_fall) || $past(start_det) || $past(stop_det) || pwr_dn || $past(pwr_dn)));

endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.NUM_REGS(NUM_REGS), .W(W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_dn        (pwr_dn),
    .sda_drive_low (sda_drive_low),
    .regs_out      (regs_out),
    .scl_fall      (scl_fall),
    .start_det     (start_det),
    .stop_det      (stop_det)
);

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb_top;

    localparam int NREG = 7;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_dn = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic sda_line;
    logic [NREG*8-1:0] regs_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf [16];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_drive_low;

    cfg_serial_slave dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_dn        (pwr_dn),
        .scl_in        (scl_m),
        .sda_in        (sda_line),
        .sda_drive_low (sda_drive_low),
        .regs_out      (regs_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int k);
        return (k < NREG) ? model[k] : 8'hFF;
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        logic early;
        sda_m = 1'b1; wq();
        scl_m = 1'b1;
        repeat (2) @(negedge clk);
        early = sda_line;
        repeat (Q - 2) @(negedge clk);
        b = sda_line;
        chk(early == b, "R9 sda steady while scl high", {31'd0, b}, {31'd0, early});
        scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic last);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(last);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            chk(regs_out[i*8 +: 8] == model[i], req, {24'd0, regs_out[i*8 +: 8]}, {24'd0, model[i]});
    endtask

    // address, two ignored bytes, n data bytes from wbuf; no START/STOP
    task automatic write_body(input int n);
        logic a;
        put_byte(8'hD2, a);
        chk(a, "R2 write address ack", {31'd0, a}, 32'd1);
        put_byte(8'($urandom), a);
        chk(a, "R2 command byte ack", {31'd0, a}, 32'd1);
        put_byte(8'($urandom), a);
        chk(a, "R2 count byte ack", {31'd0, a}, 32'd1);
        for (int k = 0; k < n; k++) begin
            put_byte(wbuf[k], a);
            if (k < NREG) begin
                model[k] = wbuf[k];
                chk(a, "R3 data byte ack", {31'd0, a}, 32'd1);
            end else begin
                chk(a, "R4 overflow byte ack", {31'd0, a}, 32'd1);
            end
        end
    endtask

    task automatic write_txn(input int n, input string req);
        bus_start();
        write_body(n);
        bus_stop();
        wq();
        check_regs(req);
    endtask

    task automatic read_txn(input int n);
        logic a;
        logic [7:0] v;
        bus_start();
        put_byte(8'hD3, a);
        chk(a, "R5 read address ack", {31'd0, a}, 32'd1);
        for (int k = 0; k < n; k++) begin
            get_byte(v, k == n - 1);
            chk(v == exp_read(k), "R5 read data", {24'd0, v}, {24'd0, exp_read(k)});
        end
        bus_stop();
        wq();
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic a;
        void'($urandom(32'd20240611));
        model[0] = 8'h00;
        for (int i = 1; i < NREG; i++) model[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset defaults and idle bus
        check_regs("R1 reset value");
        chk(sda_drive_low == 1'b0, "R1 sda released", {31'd0, sda_drive_low}, 32'd0);

        // R2: no data bytes, only the two ignored bytes
        write_txn(0, "R2 dummies ignored");

        // R3: single byte, then three bytes
        wbuf[0] = 8'h5A;
        write_txn(1, "R3 single byte");
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        write_txn(3, "R3 three bytes");
        read_txn(4);

        // R4: nine bytes, last two discarded
        for (int k = 0; k < 9; k++) wbuf[k] = 8'(8'hA0 + k);
        write_txn(9, "R4 overflow discarded");
        read_txn(9);

        // R6: foreign address
        bus_start();
        put_byte(8'hD0, a);
        chk(!a, "R6 foreign address nack", {31'd0, a}, 32'd0);
        put_byte(8'h00, a);
        chk(!a, "R6 ignored until start", {31'd0, a}, 32'd0);
        put_byte(8'h00, a);
        put_byte(8'h77, a);
        bus_stop();
        wq();
        check_regs("R6 registers unchanged");

        // R7: repeated start restarts the sequence
        bus_start();
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
        write_body(2);
        wbuf[0] = 8'h3C; wbuf[1] = 8'h4D;
        bus_start();
        write_body(2);
        bus_stop();
        wq();
        check_regs("R7 restart from register 0");

        // R8: power-down ignores the bus and holds registers
        pwr_dn = 1'b1;
        wq();
        bus_start();
        put_byte(8'hD2, a);
        chk(!a, "R8 no ack in power-down", {31'd0, a}, 32'd0);
        put_byte(8'h00, a);
        put_byte(8'h00, a);
        put_byte(8'h99, a);
        chk(!a, "R8 data not acked in power-down", {31'd0, a}, 32'd0);
        chk(sda_drive_low == 1'b0, "R8 sda released", {31'd0, sda_drive_low}, 32'd0);
        bus_stop();
        wq();
        check_regs("R8 registers held");
        pwr_dn = 1'b0;
        wq();
        read_txn(3);

        // random mix
        for (int it = 0; it < 6; it++) begin
            int n;
            n = int'($urandom_range(9, 0));
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            write_txn(n, "R3 random write");
            read_txn(int'($urandom_range(9, 1)));
        end

        report();
    end

endmodule